// File: doc/BRIEF.md
# IO Bank Freeze-Thaw Sequencer

This block steps the control lines of one general-purpose IO bank into a safe frozen state and back out again. The bank has four active-low controls and one active-high flag. The active-low controls are slew enable, weak pull-up, tristate and bus-hold. The active-high flag is configuration-done. On each change of state the lines move in a fixed order. Consecutive steps are separated by a minimum gap, counted in clock cycles.

A single-cycle freeze pulse or thaw pulse starts a sequence. While a sequence runs, a busy output is high and further requests are ignored. A status bit reports whether the bank is frozen or thawed. The bank comes out of reset frozen.

The gap parameter is the minimum step spacing (20 ns) divided by the clock period, rounded up. It is forced to at least one cycle.

Top module: `iobank_freeze_seq`

## Requirements
- R1: During and after reset, until a request is accepted: `slew_n`, `pullup_n`, `tristate_n`, `bushold_n` are 0, `cfg_done` is 0, `frozen` is 1, `busy` is 0.
- R2: A freeze request accepted from the thawed state drives `slew_n`, `pullup_n` and `tristate_n` to 0 at the accepting clock edge. At that edge `bushold_n` and `cfg_done` stay 1 and `busy` becomes 1.
- R3: STEP cycles after freeze step 1, `bushold_n` and `cfg_done` both go to 0. At the same edge `frozen` becomes 1 and `busy` returns to 0.
- R4: A thaw request accepted from the frozen state drives `bushold_n` and `cfg_done` to 1 at the accepting edge. The other three controls stay 0 and `busy` becomes 1.
- R5: STEP cycles after thaw step 1, `pullup_n` and `tristate_n` go to 1 while `slew_n` stays 0.
- R6: STEP cycles after thaw step 2, `slew_n` goes to 1. At the same edge `frozen` becomes 0 and `busy` returns to 0.
- R7: STEP equals `GAP_CYCLES`, except that a value of 0 is treated as 1.
- R8: Any freeze or thaw request sampled while `busy` is 1 has no effect on the outputs or on the step timing.
- R9: A freeze request while frozen, or a thaw request while thawed, only re-drives that state's final levels. `busy` stays 0 and `frozen` is unchanged.
- R10: When freeze and thaw requests arrive in the same idle cycle, the freeze request wins and the thaw request is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| freeze_req | input | 1 | Single-cycle freeze request |
| thaw_req | input | 1 | Single-cycle thaw request |
| slew_n | output | 1 | Slew enable, active low |
| pullup_n | output | 1 | Weak pull-up enable, active low |
| tristate_n | output | 1 | Tristate control, active low |
| bushold_n | output | 1 | Bus-hold control, active low |
| cfg_done | output | 1 | Configuration-done flag, active high |
| frozen | output | 1 | 1 = bank frozen, 0 = bank thawed |
| busy | output | 1 | High while a sequence is in progress |

## Verification
The assertions check the ordering rules on every cycle:
- slew is never released while pull-up or tristate is still held;
- pull-up and tristate are never released while bus-hold is held;
- bus-hold and configuration-done always move together;
- the frozen status changes only at the end of a sequence;
- a redundant request never raises busy.

Only the bench scenarios can show the exact cycle of each step for a given gap length and that the effective gap of 1 is used when the parameter is 0. They also show that requests issued during every busy cycle are dropped and that freeze wins over a simultaneous thaw.

// File: rtl/iofz_pkg.sv
// Package: shared types for the IO bank freeze-thaw sequencer.
// Assumes: one step command is produced per cycle at most.
package iofz_pkg;

    // Sequencer position while a multi-step sequence runs
    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_FRZ_WAIT  = 2'd1,
        ST_THW_WAIT1 = 2'd2,
        ST_THW_WAIT2 = 2'd3
    } seq_state_t;

    // Pin update applied at the next clock edge
    typedef enum logic [2:0] {
        CMD_NONE     = 3'd0,
        CMD_FRZ1     = 3'd1,
        CMD_FRZ2     = 3'd2,
        CMD_THW1     = 3'd3,
        CMD_THW2     = 3'd4,
        CMD_THW3     = 3'd5,
        CMD_HOLD_FRZ = 3'd6,
        CMD_HOLD_THW = 3'd7
    } step_cmd_t;

endpackage

// File: rtl/iofz_gap_timer.sv
// Module: minimum-gap timer.
// A start pulse arms the timer. After GAP_EFF clock edges, done is high for
// the cycle that precedes the next step edge.
// Assumes: a start pulse may coincide with done (back-to-back gaps).
module iofz_gap_timer #(
    parameter int unsigned GAP_EFF = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic done
);
    localparam int unsigned CW = $clog2(GAP_EFF + 1);

    logic [CW-1:0] cnt;
    logic          running;

    assign done = running && (cnt == '0);

    // Load on start, count down while armed, disarm once expired
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            running <= 1'b0;
        end else if (start) begin
            cnt     <= CW'(GAP_EFF - 1);
            running <= 1'b1;
        end else if (done) begin
            running <= 1'b0;
        end else if (running) begin
            cnt <= cnt - 1'b1;
        end
    end

    // R7: an armed timer never holds a count beyond the gap length
    a_r7_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (cnt <= CW'(GAP_EFF - 1)));

endmodule

// File: rtl/iofz_step_ctrl.sv
// Module: step sequencer.
// Accepts requests only when idle, with freeze taking priority over thaw.
// Issues one pin command per step and tracks the frozen status.
// Assumes: requests are single-cycle pulses; done comes from iofz_gap_timer.
module iofz_step_ctrl
    import iofz_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      freeze_req,
    input  logic      thaw_req,
    input  logic      gap_done,
    output logic      gap_start,
    output step_cmd_t cmd,
    output logic      frozen,
    output logic      busy
);
    seq_state_t state, state_nx;
    logic       frozen_nx;

    // Decide the next state, the pin command and whether a gap starts
    always_comb begin
        state_nx  = state;
        frozen_nx = frozen;
        cmd       = CMD_NONE;
        gap_start = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (freeze_req) begin
                    if (frozen) begin
                        cmd = CMD_HOLD_FRZ;
                    end else begin
                        cmd       = CMD_FRZ1;
                        gap_start = 1'b1;
                        state_nx  = ST_FRZ_WAIT;
                    end
                end else if (thaw_req) begin
                    if (!frozen) begin
                        cmd = CMD_HOLD_THW;
                    end else begin
                        cmd       = CMD_THW1;
                        gap_start = 1'b1;
                        state_nx  = ST_THW_WAIT1;
                    end
                end
            end
            ST_FRZ_WAIT: begin
                if (gap_done) begin
                    cmd       = CMD_FRZ2;
                    state_nx  = ST_IDLE;
                    frozen_nx = 1'b1;
                end
            end
            ST_THW_WAIT1: begin
                if (gap_done) begin
                    cmd       = CMD_THW2;
                    gap_start = 1'b1;
                    state_nx  = ST_THW_WAIT2;
                end
            end
            ST_THW_WAIT2: begin
                if (gap_done) begin
                    cmd       = CMD_THW3;
                    state_nx  = ST_IDLE;
                    frozen_nx = 1'b0;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // Register the sequencer position and the frozen status
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            frozen <= 1'b1;
        end else begin
            state  <= state_nx;
            frozen <= frozen_nx;
        end
    end

    assign busy = (state != ST_IDLE);

    // R8: status flips only on the edge that ends a sequence
    a_r8_status_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(frozen) |-> ($past(busy) && !busy));

    // R9: a redundant request leaves the sequencer idle
    a_r9_hold_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && ((freeze_req && frozen) || (!freeze_req && thaw_req && !frozen)))
            |=> !busy);

    // R10: a freeze request from thawed idle never starts a thaw
    a_r10_freeze_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && freeze_req && !frozen) |=> (state == ST_FRZ_WAIT));

endmodule

// File: rtl/iofz_pin_reg.sv
// Module: IO control line registers.
// Applies each step command to the five control lines. The reset value is
// the frozen safe state.
// Assumes: commands arrive in a legal order from iofz_step_ctrl.
module iofz_pin_reg
    import iofz_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  step_cmd_t cmd,
    output logic      slew_n,
    output logic      pullup_n,
    output logic      tristate_n,
    output logic      bushold_n,
    output logic      cfg_done
);
    // Update the control lines for the commanded step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slew_n     <= 1'b0;
            pullup_n   <= 1'b0;
            tristate_n <= 1'b0;
            bushold_n  <= 1'b0;
            cfg_done   <= 1'b0;
        end else begin
            unique case (cmd)
                CMD_FRZ1: begin
                    slew_n     <= 1'b0;
                    pullup_n   <= 1'b0;
                    tristate_n <= 1'b0;
                end
                CMD_FRZ2: begin
                    bushold_n <= 1'b0;
                    cfg_done  <= 1'b0;
                end
                CMD_THW1: begin
                    bushold_n <= 1'b1;
                    cfg_done  <= 1'b1;
                end
                CMD_THW2: begin
                    pullup_n   <= 1'b1;
                    tristate_n <= 1'b1;
                end
                CMD_THW3: slew_n <= 1'b1;
                CMD_HOLD_FRZ: begin
                    slew_n     <= 1'b0;
                    pullup_n   <= 1'b0;
                    tristate_n <= 1'b0;
                    bushold_n  <= 1'b0;
                    cfg_done   <= 1'b0;
                end
                CMD_HOLD_THW: begin
                    slew_n     <= 1'b1;
                    pullup_n   <= 1'b1;
                    tristate_n <= 1'b1;
                    bushold_n  <= 1'b1;
                    cfg_done   <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    // R3/R4: bus-hold and config-done always move together
    a_r3_hold_tracks_cfg: assert property (@(posedge clk) disable iff (!rst_n)
        bushold_n == cfg_done);

    // R5: pull-up and tristate are released only once bus-hold is released
    a_r5_release_after_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (pullup_n || tristate_n) |-> bushold_n);

    // R6: slew is released last
    a_r6_slew_last: assert property (@(posedge clk) disable iff (!rst_n)
        slew_n |-> (pullup_n && tristate_n));

endmodule

// File: rtl/iobank_freeze_seq.sv
// Module: IO bank freeze-thaw sequencer (top).
// Connects the step sequencer, the gap timer and the pin registers.
// Assumes: GAP_CYCLES = ceil(min step spacing / clock period); 0 means 1.
module iobank_freeze_seq
    import iofz_pkg::*;
#(
    parameter int unsigned GAP_CYCLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic freeze_req,
    input  logic thaw_req,
    output logic slew_n,
    output logic pullup_n,
    output logic tristate_n,
    output logic bushold_n,
    output logic cfg_done,
    output logic frozen,
    output logic busy
);
    localparam int unsigned GAP_EFF = (GAP_CYCLES < 1) ? 1 : GAP_CYCLES;

    logic      gap_start;
    logic      gap_done;
    step_cmd_t cmd;

    iofz_step_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .freeze_req(freeze_req),
        .thaw_req  (thaw_req),
        .gap_done  (gap_done),
        .gap_start (gap_start),
        .cmd       (cmd),
        .frozen    (frozen),
        .busy      (busy)
    );

    iofz_gap_timer #(.GAP_EFF(GAP_EFF)) u_gap (
        .clk  (clk),
        .rst_n(rst_n),
        .start(gap_start),
        .done (gap_done)
    );

    iofz_pin_reg u_pins (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd       (cmd),
        .slew_n    (slew_n),
        .pullup_n  (pullup_n),
        .tristate_n(tristate_n),
        .bushold_n (bushold_n),
        .cfg_done  (cfg_done)
    );

    // R2: a freeze step never touches the lines while idle and not requested
    a_r2_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !freeze_req && !thaw_req)
            |=> ($stable(slew_n) && $stable(pullup_n) && $stable(bushold_n)));

endmodule

// File: tb/tb_iobank_freeze_seq.sv
// Bench: mixes random requests (fixed seed) with directed corner cases.
// Expected outputs come from the exp_out function, which encodes the requirements.
module tb_iobank_freeze_seq;
    localparam int G = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic freeze_req = 1'b0, thaw_req = 1'b0;
    logic slew_n, pullup_n, tristate_n, bushold_n, cfg_done, frozen, busy;
    logic frz0 = 1'b0, thw0 = 1'b0;
    logic s0, p0, t0, b0, c0, f0, y0;

    int checks = 0;
    int errors = 0;
    bit model_frozen;

    always #10 clk = ~clk;

    iobank_freeze_seq #(.GAP_CYCLES(G)) dut (
        .clk(clk), .rst_n(rst_n), .freeze_req(freeze_req), .thaw_req(thaw_req),
        .slew_n(slew_n), .pullup_n(pullup_n), .tristate_n(tristate_n),
        .bushold_n(bushold_n), .cfg_done(cfg_done), .frozen(frozen), .busy(busy));

    iobank_freeze_seq #(.GAP_CYCLES(0)) dut_g0 (
        .clk(clk), .rst_n(rst_n), .freeze_req(frz0), .thaw_req(thw0),
        .slew_n(s0), .pullup_n(p0), .tristate_n(t0),
        .bushold_n(b0), .cfg_done(c0), .frozen(f0), .busy(y0));

    // kind: 0 freeze run, 1 thaw run, 2 hold frozen, 3 hold thawed.
    // Result order: slew_n, pullup_n, tristate_n, bushold_n, cfg_done, frozen, busy.
    function automatic logic [6:0] exp_out(int kind, int t, int g);
        case (kind)
            0: return (t < g) ? 7'b0001101 : 7'b0000010;
            1: if (t < g) return 7'b0001111;
               else if (t < 2 * g) return 7'b0111111;
               else return 7'b1111100;
            2: return 7'b0000010;
            default: return 7'b1111100;
        endcase
    endfunction

    function automatic string req_of(int kind, int t);
        case (kind)
            0: return (t < G) ? "R2" : "R3";
            1: return (t < G) ? "R4" : ((t < 2 * G) ? "R5" : "R6");
            default: return "R9";
        endcase
    endfunction

    task automatic check(string req, logic [6:0] got, logic [6:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
        end
    endtask

    function automatic logic [6:0] pins();
        return {slew_n, pullup_n, tristate_n, bushold_n, cfg_done, frozen, busy};
    endfunction

    // Issue one request and check every cycle until the sequence ends.
    // If junk is set, random requests are driven during busy cycles (R8).
    task automatic run_req(bit frz, bit thw, bit junk, string tag);
        int kind;
        int len;
        if (frz) kind = model_frozen ? 2 : 0;
        else     kind = model_frozen ? 1 : 3;
        len = (kind == 0) ? G : ((kind == 1) ? 2 * G : 0);
        freeze_req = frz;
        thaw_req   = thw;
        @(negedge clk);
        for (int t = 0; t <= len; t++) begin
            if (t > 0) @(negedge clk);
            check((tag != "") ? tag : req_of(kind, t), pins(), exp_out(kind, t, G));
            if (junk && t < len) begin
                freeze_req = 1'($urandom % 2);
                thaw_req   = 1'($urandom % 2);
            end else begin
                freeze_req = 1'b0;
                thaw_req   = 1'b0;
            end
        end
        if (kind == 0) model_frozen = 1'b1;
        if (kind == 1) model_frozen = 1'b0;
    endtask

    // Watchdog: an expired run counts as a failure and still reports
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        model_frozen = 1'b1;
        repeat (3) @(negedge clk);
        check("R1", pins(), 7'b0000010);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1", pins(), 7'b0000010);

        // R9: freeze while frozen re-drives the frozen levels, busy stays low
        run_req(1'b1, 1'b0, 1'b0, "R9");
        // R4/R5/R6: thaw from frozen, with no junk requests
        run_req(1'b0, 1'b1, 1'b0, "");
        // R9: thaw while thawed
        run_req(1'b0, 1'b1, 1'b0, "R9");
        // R10: simultaneous requests from thawed start a freeze
        run_req(1'b1, 1'b1, 1'b0, "R10");
        // R8: thaw with random requests on every busy cycle
        run_req(1'b0, 1'b1, 1'b1, "R8");
        // R8: freeze with random requests on every busy cycle
        run_req(1'b1, 1'b0, 1'b1, "R8");

        // R7: a zero gap parameter behaves as a one-cycle gap
        thw0 = 1'b1;
        @(negedge clk);
        thw0 = 1'b0;
        check("R7", {s0, p0, t0, b0, c0, f0, y0}, exp_out(1, 0, 1));
        @(negedge clk);
        check("R7", {s0, p0, t0, b0, c0, f0, y0}, exp_out(1, 1, 1));
        @(negedge clk);
        check("R7", {s0, p0, t0, b0, c0, f0, y0}, exp_out(1, 2, 1));
        frz0 = 1'b1;
        @(negedge clk);
        frz0 = 1'b0;
        check("R7", {s0, p0, t0, b0, c0, f0, y0}, exp_out(0, 0, 1));
        @(negedge clk);
        check("R7", {s0, p0, t0, b0, c0, f0, y0}, exp_out(0, 1, 1));

        // Random mix of requests and idle gaps
        for (int i = 0; i < 80; i++) begin
            int op;
            op = int'($urandom % 4);
            case (op)
                0: run_req(1'b1, 1'b0, 1'($urandom % 2), "");
                1: run_req(1'b0, 1'b1, 1'($urandom % 2), "");
                2: run_req(1'b1, 1'b1, 1'b0, "R10");
                default: begin
                    repeat (1 + ($urandom % 3)) @(negedge clk);
                    check("R9", pins(), model_frozen ? 7'b0000010 : 7'b1111100);
                end
            endcase
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule